// File: doc/BRIEF.md
# Pipelined Radix-4 Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor of the same width. It returns both the quotient and the remainder. The work is spread over a chain of identical pipeline stages, and each stage retires one base-4 quotient digit, which is two quotient bits. With the default width of 6 bits the chain has three stages. An operand pair can enter on every clock cycle. Each result leaves a fixed number of cycles later, carrying the valid bit that came in with it. There is no stall path.

When the operands enter, the divisor is expanded once into its single, double and triple multiples. Those three values travel with the data through the pipeline registers. Inside a stage, the partial remainder is shifted left by two places and the next two dividend bits are appended. The result is compared against the three stored multiples, and the three compare outputs form a thermometer code. That code alone selects the digit. A single subtractor then removes the chosen multiple, or nothing for a digit of zero.

A zero divisor does not produce a meaningful division. In that case the block returns a quotient of all ones and a remainder equal to the dividend, and it raises a flag that is aligned with that result.

Top module: `div4_top`

## Requirements
- R1: Operands sampled with `in_vld` high at rising edge k appear on the outputs with `out_vld` high just after rising edge k+2, which is three register stages after capture for the default width.
- R2: A new operand pair may be presented on every cycle; back-to-back pairs yield back-to-back results, each independent of its neighbours.
- R3: For a nonzero divisor, `out_quotient` equals the integer quotient floor(dividend / divisor).
- R4: For a nonzero divisor, `out_remainder` equals dividend mod divisor and is strictly less than the divisor.
- R5: For a zero divisor, `out_quotient` is all ones, `out_remainder` equals the dividend and `out_div0` is 1; for a nonzero divisor `out_div0` is 0.
- R6: While `rst_ni` is low, and on the first cycle after it is released, `out_vld` is 0.
- R7: A cycle with `in_vld` low yields `out_vld` low at the matching output cycle, which leaves a bubble in the result stream.
- R8: The width must be even, and the stage count is half the width; the quotient digit of each stage is the number of divisor multiples (0 to 3) that do not exceed the shifted partial remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand pair present this cycle |
| in_dividend | input | WIDTH | Unsigned dividend |
| in_divisor | input | WIDTH | Unsigned divisor |
| out_vld | output | 1 | Result present this cycle |
| out_quotient | output | WIDTH | Quotient |
| out_remainder | output | WIDTH | Remainder |
| out_div0 | output | 1 | Result came from a zero divisor |

## Verification
Every dividend and divisor pair of the 6-bit configuration is streamed through back to back. This sweep exercises all four digit values in every stage. It also covers the boundary pairs: a zero dividend, a divisor of one, a divisor above the dividend, maximum operands and a zero divisor. Because neighbouring results differ, a misrouted or mis-timed pipeline register shows up as a wrong value rather than a coincidental match. Bubbles are placed at irregular points in the stream, which separates correct valid-bit tracking from an output that is simply held high.

// File: rtl/div4_pkg.sv
package div4_pkg;

    // Base-4 quotient digit retired by one stage
    typedef enum logic [1:0] {
        DIG0 = 2'd0,
        DIG1 = 2'd1,
        DIG2 = 2'd2,
        DIG3 = 2'd3
    } digit_e;

    // Thermometer code from three comparators -> digit
    function automatic digit_e pick_digit(input logic ge1, input logic ge2, input logic ge3);
        digit_e d;
        d = DIG0;
        if (ge3)      d = DIG3;
        else if (ge2) d = DIG2;
        else if (ge1) d = DIG1;
        return d;
    endfunction

endpackage

// File: rtl/div4_mult.sv
module div4_mult #(
    parameter int WIDTH = 6
) (
    input  logic [WIDTH-1:0]   divisor_i,
    output logic [WIDTH+1:0]   m1_o,
    output logic [WIDTH+1:0]   m2_o,
    output logic [WIDTH+1:0]   m3_o,
    output logic               zero_o
);
    localparam int RW = WIDTH + 2;

    always_comb begin
        m1_o   = RW'(divisor_i);
        m2_o   = RW'({divisor_i, 1'b0});
        m3_o   = m1_o + m2_o;
        zero_o = (divisor_i == '0);
    end
endmodule

// File: rtl/div4_stage.sv
module div4_stage
    import div4_pkg::*;
#(
    parameter int WIDTH = 6,
    parameter int IDX   = 0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               vld_i,
    input  logic               dz_i,
    input  logic [WIDTH-1:0]   dvd_i,
    input  logic [WIDTH-1:0]   rem_i,
    input  logic [WIDTH-1:0]   quo_i,
    input  logic [WIDTH+1:0]   m1_i,
    input  logic [WIDTH+1:0]   m2_i,
    input  logic [WIDTH+1:0]   m3_i,
    output logic               vld_o,
    output logic               dz_o,
    output logic [WIDTH-1:0]   dvd_o,
    output logic [WIDTH-1:0]   rem_o,
    output logic [WIDTH-1:0]   quo_o,
    output logic [WIDTH+1:0]   m1_o,
    output logic [WIDTH+1:0]   m2_o,
    output logic [WIDTH+1:0]   m3_o
);
    localparam int RW = WIDTH + 2;
    localparam int HI = WIDTH - 1 - 2 * IDX;   // top of this stage's dividend pair

    typedef struct packed {
        logic             vld;
        logic             dz;
        logic [WIDTH-1:0] dvd;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] quo;
        logic [RW-1:0]    m1;
        logic [RW-1:0]    m2;
        logic [RW-1:0]    m3;
    } stg_t;

    stg_t             st_d, st_q;
    logic [RW-1:0]    shifted_d;
    logic [WIDTH-1:0] sub_d;
    digit_e           dig_d;

    always_comb begin
        shifted_d = {rem_i, dvd_i[HI -: 2]};
        dig_d     = pick_digit(shifted_d >= m1_i, shifted_d >= m2_i, shifted_d >= m3_i);
        unique case (dig_d)
            DIG3:    sub_d = m3_i[WIDTH-1:0];
            DIG2:    sub_d = m2_i[WIDTH-1:0];
            DIG1:    sub_d = m1_i[WIDTH-1:0];
            default: sub_d = '0;
        endcase
        st_d.vld = vld_i;
        st_d.dz  = dz_i;
        st_d.dvd = dvd_i;
        st_d.rem = shifted_d[WIDTH-1:0] - sub_d;
        st_d.quo = {quo_i[WIDTH-3:0], dig_d};
        st_d.m1  = m1_i;
        st_d.m2  = m2_i;
        st_d.m3  = m3_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign dz_o  = st_q.dz;
    assign dvd_o = st_q.dvd;
    assign rem_o = st_q.rem;
    assign quo_o = st_q.quo;
    assign m1_o  = st_q.m1;
    assign m2_o  = st_q.m2;
    assign m3_o  = st_q.m3;
endmodule

// File: rtl/div4_top.sv
module div4_top #(
    parameter int WIDTH = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               in_vld,
    input  logic [WIDTH-1:0]   in_dividend,
    input  logic [WIDTH-1:0]   in_divisor,
    output logic               out_vld,
    output logic [WIDTH-1:0]   out_quotient,
    output logic [WIDTH-1:0]   out_remainder,
    output logic               out_div0
);
    localparam int RW   = WIDTH + 2;
    localparam int NSTG = WIDTH / 2;

    logic             vld_c [NSTG+1];
    logic             dz_c  [NSTG+1];
    logic [WIDTH-1:0] dvd_c [NSTG+1];
    logic [WIDTH-1:0] rem_c [NSTG+1];
    logic [WIDTH-1:0] quo_c [NSTG+1];
    logic [RW-1:0]    m1_c  [NSTG+1];
    logic [RW-1:0]    m2_c  [NSTG+1];
    logic [RW-1:0]    m3_c  [NSTG+1];

    div4_mult #(.WIDTH(WIDTH)) i_mult (
        .divisor_i (in_divisor),
        .m1_o      (m1_c[0]),
        .m2_o      (m2_c[0]),
        .m3_o      (m3_c[0]),
        .zero_o    (dz_c[0])
    );

    assign vld_c[0] = in_vld;
    assign dvd_c[0] = in_dividend;
    assign rem_c[0] = '0;
    assign quo_c[0] = '0;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        div4_stage #(.WIDTH(WIDTH), .IDX(s)) i_stage (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .vld_i  (vld_c[s]),
            .dz_i   (dz_c[s]),
            .dvd_i  (dvd_c[s]),
            .rem_i  (rem_c[s]),
            .quo_i  (quo_c[s]),
            .m1_i   (m1_c[s]),
            .m2_i   (m2_c[s]),
            .m3_i   (m3_c[s]),
            .vld_o  (vld_c[s+1]),
            .dz_o   (dz_c[s+1]),
            .dvd_o  (dvd_c[s+1]),
            .rem_o  (rem_c[s+1]),
            .quo_o  (quo_c[s+1]),
            .m1_o   (m1_c[s+1]),
            .m2_o   (m2_c[s+1]),
            .m3_o   (m3_c[s+1])
        );
    end

    always_comb begin
        out_vld       = vld_c[NSTG];
        out_div0      = dz_c[NSTG];
        out_quotient  = dz_c[NSTG] ? '1 : quo_c[NSTG];
        out_remainder = dz_c[NSTG] ? dvd_c[NSTG] : rem_c[NSTG];
    end

    // Multiples of the last stage are not consumed further
    logic unused_m;
    assign unused_m = ^{m1_c[NSTG], m2_c[NSTG], m3_c[NSTG]};
endmodule

// File: rtl/div4_chk.sv
module div4_chk #(
    parameter int WIDTH = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             in_vld,
    input logic [WIDTH-1:0] in_dividend,
    input logic [WIDTH-1:0] in_divisor,
    input logic             out_vld,
    input logic [WIDTH-1:0] out_quotient,
    input logic [WIDTH-1:0] out_remainder,
    input logic             out_div0
);
    localparam int NSTG = WIDTH / 2;

    logic             vsr [NSTG];
    logic [WIDTH-1:0] asr [NSTG];
    logic [WIDTH-1:0] bsr [NSTG];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NSTG; i++) begin
                vsr[i] <= 1'b0;
                asr[i] <= '0;
                bsr[i] <= '0;
            end
        end else begin
            vsr[0] <= in_vld;
            asr[0] <= in_dividend;
            bsr[0] <= in_divisor;
            for (int i = 1; i < NSTG; i++) begin
                vsr[i] <= vsr[i-1];
                asr[i] <= asr[i-1];
                bsr[i] <= bsr[i-1];
            end
        end
    end

    logic [2*WIDTH-1:0] recon;
    assign recon = out_quotient * bsr[NSTG-1] + (2*WIDTH)'(out_remainder);

    // R1 R7
    vld_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld == vsr[NSTG-1]);

    // R3
    div_identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_vld && !out_div0) |-> recon == (2*WIDTH)'(asr[NSTG-1]));

    // R4
    rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_vld && !out_div0) |-> out_remainder < bsr[NSTG-1]);

    // R5
    div0_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld |-> out_div0 == (bsr[NSTG-1] == '0));

    // R5
    div0_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_vld && out_div0) |-> (out_quotient == '1 && out_remainder == asr[NSTG-1]));

    // R6
    reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !out_vld);
endmodule

bind div4_top div4_chk #(.WIDTH(WIDTH)) i_div4_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_vld        (in_vld),
    .in_dividend   (in_dividend),
    .in_divisor    (in_divisor),
    .out_vld       (out_vld),
    .out_quotient  (out_quotient),
    .out_remainder (out_remainder),
    .out_div0      (out_div0)
);

// File: tb/test_div4_top.sv
module test_div4_top;
    localparam int WIDTH      = 6;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV       = (1 << WIDTH) - 1;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             in_vld = 1'b0;
    logic [WIDTH-1:0] in_dividend = '0;
    logic [WIDTH-1:0] in_divisor = '0;
    logic             out_vld;
    logic [WIDTH-1:0] out_quotient;
    logic [WIDTH-1:0] out_remainder;
    logic             out_div0;

    int checks = 0;
    int errors = 0;

    // history of applied operands, index 2 = applied three negedges ago
    logic             hv [3];
    logic [WIDTH-1:0] ha [3];
    logic [WIDTH-1:0] hb [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    div4_top #(.WIDTH(WIDTH)) i_div4_top (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .in_vld        (in_vld),
        .in_dividend   (in_dividend),
        .in_divisor    (in_divisor),
        .out_vld       (out_vld),
        .out_quotient  (out_quotient),
        .out_remainder (out_remainder),
        .out_div0      (out_div0)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_out();
        int eq, er, ez;
        // R1 R7: valid bit tracks the slot from three stages back
        chk("R1/R7 out_vld", int'(out_vld), int'(hv[2]));
        if (hv[2]) begin
            if (hb[2] == 0) begin
                eq = MAXV; er = int'(ha[2]); ez = 1;
                chk("R5 div0 quotient", int'(out_quotient), eq);
                chk("R5 div0 remainder", int'(out_remainder), er);
                chk("R5 div0 flag", int'(out_div0), ez);
            end else begin
                eq = int'(ha[2]) / int'(hb[2]);
                er = int'(ha[2]) % int'(hb[2]);
                // R2: results of back-to-back pairs are checked one per cycle
                chk("R2/R3 quotient", int'(out_quotient), eq);
                chk("R4 remainder", int'(out_remainder), er);
                chk("R5 no-div0 flag", int'(out_div0), 0);
            end
        end
    endtask

    task automatic step(input logic v, input int a, input int b);
        @(negedge clk);
        compare_out();
        hv[2] = hv[1]; ha[2] = ha[1]; hb[2] = hb[1];
        hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0];
        hv[0] = v; ha[0] = WIDTH'(a); hb[0] = WIDTH'(b);
        in_vld      = v;
        in_dividend = WIDTH'(a);
        in_divisor  = WIDTH'(b);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; ha[i] = '0; hb[i] = '0;
        end
        // R6: quiet during reset even with operands presented
        in_vld = 1'b1; in_dividend = 6'd40; in_divisor = 6'd3;
        repeat (4) begin
            @(negedge clk);
            chk("R6 out_vld in reset", int'(out_vld), 0);
        end
        in_vld = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        chk("R6 out_vld after reset", int'(out_vld), 0);

        // R8: all digit values in every stage via exhaustive sweep
        for (int a = 0; a <= MAXV; a++) begin
            for (int b = 0; b <= MAXV; b++) begin
                step(1'b1, a, b);
                if ((a * 7 + b) % 13 == 0) step(1'b0, b, a); // R7 bubble
            end
        end
        // corner pairs back to back
        step(1'b1, 0, 1);
        step(1'b1, MAXV, 1);
        step(1'b1, 5, MAXV);
        step(1'b1, MAXV, MAXV);
        step(1'b1, MAXV, 0);
        step(1'b1, 0, 0);
        step(1'b0, MAXV, 2);
        step(1'b1, 63, 2);
        for (int k = 0; k < 4; k++) step(1'b0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule